// File: doc/BRIEF.md
# Fetch-Side Fully Associative Instruction Cache

This block sits between an instruction fetch stage and a simple word-serial memory port. The fetch stage presents an address every cycle. If the word is resident, the block returns it in the same cycle, with no register between address and data. If the word is not resident, the block loads the whole four-word line into a victim line. It asks memory for the missed word first and then walks the rest of the line in wrapped order. The fetch stage can use the missed word as soon as it has been written, before the rest of the line arrives.

Any line can hold any address. The victim is always the line that was filled longest ago, chosen by a rotating pointer that moves one step after each completed fill. An output multiplexer sits in front of the fetch port. It shows a fixed no-operation word while the fetched address is absent. It substitutes a fixed interrupt word whenever an interrupt is pending. A flush input empties the cache in one cycle.

Top module: `icacheFetch`

## Requirements
- R1: The cache has 64 lines of four 32-bit words. The tag is address bits [31:4] and the word index is bits [3:2]. Any tag may sit in any line, and at most one line matches a given address.
- R2: When the addressed word is resident, `fetchHit` is 1 and `fetchInstr` carries that word in the same cycle as `fetchAddr`.
- R3: A miss seen while no fill is running starts a fill on the next clock into the line named by the replacement pointer. The pointer advances by one, wrapping from 63 to 0, after every completed fill. So the 65th distinct line filled after a flush evicts the first, and the second stays resident.
- R4: A fill performs exactly four word accesses. `memReq` stays high with `memAddr` unchanged until `memValid` accepts the word.
- R5: The first `memAddr` of a fill is the missed word (same tag, same bits [3:2]). Each following request adds one to bits [3:2] modulo 4 and keeps the tag.
- R6: A word of a filling line hits from the cycle after its `memValid`, even before the fill ends. A word not yet written still misses. A miss during a fill waits and does not start a second fill.
- R7: While the addressed word is not resident and no interrupt is pending, `fetchInstr` is the NOP word 32'hF000_0000 and `fetchHit` is 0.
- R8: While `intPending` is 1, `fetchInstr` is the interrupt word 32'hF100_0000. `fetchHit` and the fill activity are unaffected.
- R9: `flushAll` makes every address miss from the next cycle. It returns the replacement pointer to line 0 and drops any running fill, so `memReq` is 0 the next cycle.
- R10: After reset no line is valid, the pointer is at line 0, and `memReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flushAll | input | 1 | Invalidate every line and reset the pointer |
| fetchAddr | input | 32 | Fetch address, byte aligned to words |
| intPending | input | 1 | Interrupt pending, selects the interrupt word |
| fetchHit | output | 1 | Addressed word is resident |
| fetchInstr | output | 32 | Instruction word to the fetch stage |
| memReq | output | 1 | Word request to memory, held until accepted |
| memAddr | output | 32 | Word address of the request |
| memValid | input | 1 | Memory returns the requested word this cycle |
| memData | input | 32 | Returned word |

## Verification
A stuck or mis-stepping replacement pointer gives no sign on the very next fill. It only shows once the cache wraps: a line evicted too early, or a line surviving past 64 newer fills, changes `fetchHit` at the first revisit. The bench therefore fills 65 distinct lines after a flush before probing. A wrong critical-word index or wrap step shows on `memAddr` in the first cycle of the fill, or one cycle after an accepted word. Lost valid bits show as a one-cycle-late hit, or a NOP where an instruction was due.

// File: rtl/icachePkg.sv
package icachePkg;
  // Strobes from the fill controller to the storage datapath.
  typedef struct packed {
    logic startFill;  // claim victim line: write tag, clear its word valids
    logic writeWord;  // store the returned memory word
    logic clearAll;   // drop every valid bit
  } icStrobe_t;
endpackage

// File: rtl/icacheDatapath.sv
module icacheDatapath
  import icachePkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 64,
  parameter int WORDS     = 4,
  parameter logic [DATA_W-1:0] NOP_WORD = 32'hF000_0000,
  parameter logic [DATA_W-1:0] INT_WORD = 32'hF100_0000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  icStrobe_t                     strobe,
  input  logic [$clog2(NUM_LINES)-1:0]  fillLine,
  input  logic [ADDR_W-$clog2(WORDS)-3:0] fillTag,
  input  logic [$clog2(WORDS)-1:0]      fillIdx,
  input  logic [DATA_W-1:0]             fillData,
  input  logic [ADDR_W-1:0]             fetchAddr,
  input  logic                          intPending,
  output logic                          hit,
  output logic [DATA_W-1:0]             instr
);
  localparam int LINE_W = $clog2(NUM_LINES);
  localparam int WIDX_W = $clog2(WORDS);
  localparam int OFF_W  = WIDX_W + 2;
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int SLOTS  = NUM_LINES * WORDS;

  logic [TAG_W-1:0]  tagArr  [NUM_LINES];
  logic [WORDS-1:0]  wordVld [NUM_LINES];
  logic [DATA_W-1:0] dataArr [SLOTS];

  logic [TAG_W-1:0]     reqTag;
  logic [WIDX_W-1:0]    reqIdx;
  logic [NUM_LINES-1:0] matchVec;
  logic [DATA_W-1:0]    hitData;

  assign reqTag = fetchAddr[ADDR_W-1:OFF_W];
  assign reqIdx = fetchAddr[OFF_W-1:2];

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearAll) begin
      for (int i = 0; i < NUM_LINES; i++) wordVld[i] <= '0;
    end else if (strobe.startFill) begin
      wordVld[fillLine] <= '0;
    end else if (strobe.writeWord) begin
      wordVld[fillLine][fillIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.startFill && !strobe.clearAll) tagArr[fillLine] <= fillTag;
  end

  always_ff @(posedge clk) begin
    if (strobe.writeWord) dataArr[{fillLine, fillIdx}] <= fillData;
  end

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : gMatch
      assign matchVec[g] = wordVld[g][reqIdx] && (tagArr[g] == reqTag);
    end
  endgenerate

  always_comb begin
    hitData = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (matchVec[i]) hitData = hitData | dataArr[{LINE_W'(i), reqIdx}];
    end
  end

  assign hit   = |matchVec;
  assign instr = intPending ? INT_WORD : (hit ? hitData : NOP_WORD);

  // R1: a fetch address never matches two lines
  assert_unique_match_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));
endmodule

// File: rtl/icacheControl.sv
module icacheControl
  import icachePkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_LINES = 64,
  parameter int WORDS     = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          flushAll,
  input  logic                          miss,
  input  logic [ADDR_W-1:0]             fetchAddr,
  input  logic                          memValid,
  output icStrobe_t                     strobe,
  output logic [$clog2(NUM_LINES)-1:0]  fillLine,
  output logic [ADDR_W-$clog2(WORDS)-3:0] fillTag,
  output logic [$clog2(WORDS)-1:0]      fillIdx,
  output logic                          memReq,
  output logic [ADDR_W-1:0]             memAddr
);
  localparam int LINE_W = $clog2(NUM_LINES);
  localparam int WIDX_W = $clog2(WORDS);
  localparam int OFF_W  = WIDX_W + 2;
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam logic [WIDX_W-1:0] LAST_BEAT = WIDX_W'(WORDS - 1);

  typedef enum logic {IC_IDLE, IC_FILL} icState_e;

  icState_e          state;
  logic [LINE_W-1:0] replPtr;
  logic [LINE_W-1:0] victimQ;
  logic [TAG_W-1:0]  tagQ;
  logic [WIDX_W-1:0] critQ;
  logic [WIDX_W-1:0] beat;
  logic              lastWord;

  assign strobe.clearAll  = flushAll;
  assign strobe.startFill = (state == IC_IDLE) && miss && !flushAll;
  assign strobe.writeWord = (state == IC_FILL) && memValid && !flushAll;
  assign lastWord         = strobe.writeWord && (beat == LAST_BEAT);

  assign fillIdx  = critQ + beat;
  assign fillLine = strobe.startFill ? replPtr : victimQ;
  assign fillTag  = strobe.startFill ? fetchAddr[ADDR_W-1:OFF_W] : tagQ;
  assign memReq   = (state == IC_FILL);
  assign memAddr  = {tagQ, fillIdx, 2'b00};

  always_ff @(posedge clk) begin
    if (!rstN || flushAll) begin
      state   <= IC_IDLE;
      replPtr <= '0;
      victimQ <= '0;
      tagQ    <= '0;
      critQ   <= '0;
      beat    <= '0;
    end else if (strobe.startFill) begin
      state   <= IC_FILL;
      victimQ <= replPtr;
      tagQ    <= fetchAddr[ADDR_W-1:OFF_W];
      critQ   <= fetchAddr[OFF_W-1:2];
      beat    <= '0;
    end else if (strobe.writeWord) begin
      if (lastWord) begin
        state   <= IC_IDLE;
        replPtr <= replPtr + 1'b1;
      end else begin
        beat <= beat + 1'b1;
      end
    end
  end

  // R5: the fill opens on the missed word of the missed line
  assert_crit_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startFill |=> memReq && (memAddr[OFF_W-1:2] == $past(fetchAddr[OFF_W-1:2]))
                        && (memAddr[ADDR_W-1:OFF_W] == $past(fetchAddr[ADDR_W-1:OFF_W])));

  // R5: after an accepted word the next request is the following word, wrapped
  assert_wrap_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeWord && !lastWord) |=> memReq
      && (memAddr[OFF_W-1:2] == WIDX_W'($past(memAddr[OFF_W-1:2]) + 1'b1))
      && $stable(memAddr[ADDR_W-1:OFF_W]));

  // R4: an unanswered request is held steady
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid && !flushAll) |=> memReq && $stable(memAddr));

  // R3: every completed fill steps the victim pointer by one
  assert_ptr_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    lastWord |=> (replPtr == LINE_W'($past(replPtr) + 1'b1)) && !memReq);
endmodule

// File: rtl/icacheFetch.sv
module icacheFetch
  import icachePkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 64,
  parameter int WORDS     = 4,
  parameter logic [DATA_W-1:0] NOP_WORD = 32'hF000_0000,
  parameter logic [DATA_W-1:0] INT_WORD = 32'hF100_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushAll,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              intPending,
  output logic              fetchHit,
  output logic [DATA_W-1:0] fetchInstr,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [DATA_W-1:0] memData
);
  localparam int LINE_W = $clog2(NUM_LINES);
  localparam int WIDX_W = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - WIDX_W - 2;

  icStrobe_t         strobe;
  logic [LINE_W-1:0] fillLine;
  logic [TAG_W-1:0]  fillTag;
  logic [WIDX_W-1:0] fillIdx;

  icacheControl #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .WORDS(WORDS)) ctrl_i (
    .clk(clk), .rstN(rstN), .flushAll(flushAll), .miss(!fetchHit),
    .fetchAddr(fetchAddr), .memValid(memValid), .strobe(strobe),
    .fillLine(fillLine), .fillTag(fillTag), .fillIdx(fillIdx),
    .memReq(memReq), .memAddr(memAddr)
  );

  icacheDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINES(NUM_LINES),
                   .WORDS(WORDS), .NOP_WORD(NOP_WORD), .INT_WORD(INT_WORD)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fillLine(fillLine),
    .fillTag(fillTag), .fillIdx(fillIdx), .fillData(memData),
    .fetchAddr(fetchAddr), .intPending(intPending),
    .hit(fetchHit), .instr(fetchInstr)
  );

  // R9: a flush leaves nothing resident and no fill running
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> !fetchHit && !memReq);
endmodule

// File: tb/icacheFetch_tb_top.sv
module icacheFetch_tb_top;
  localparam logic [31:0] NOP_W = 32'hF000_0000;
  localparam logic [31:0] INT_W = 32'hF100_0000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        flushAll;
  logic [31:0] fetchAddr;
  logic        intPending;
  logic        fetchHit;
  logic [31:0] fetchInstr;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memValid;
  logic [31:0] memData;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;  // 50 MHz

  icacheFetch dut_i (
    .clk(clk), .rstN(rstN), .flushAll(flushAll), .fetchAddr(fetchAddr),
    .intPending(intPending), .fetchHit(fetchHit), .fetchInstr(fetchInstr),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData)
  );

  // reference model: resident tags by slot, fill in progress, victim counter
  logic [27:0] mTag [64];
  logic [3:0]  mVld [64];
  int          mPtr;
  bit          mFill;
  logic [27:0] mFTag;
  int          mCrit, mBeat, mSlot;

  function automatic logic [31:0] memFn(logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  function automatic bit mHit(logic [31:0] a);
    for (int s = 0; s < 64; s++)
      if (mVld[s][a[3:2]] && mTag[s] == a[31:4]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] mMemAddr();
    return {mFTag, 2'((mCrit + mBeat) % 4), 2'b00};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit rnd();
    return $urandom_range(0, 2) != 0;
  endfunction

  // one clock: drive, compare at negedge, advance model at posedge
  task automatic step(logic [31:0] a, bit ip, bit fl, bit mv,
                      int expHit = -1, string tag = "");
    bit h;
    logic [31:0] ma;
    fetchAddr  = a;
    intPending = ip;
    flushAll   = fl;
    ma         = mMemAddr();
    memValid   = mv;
    memData    = memFn(ma);
    h = mHit(a);
    @(negedge clk);
    check("R2 hit flag", {31'b0, fetchHit}, {31'b0, h});
    if (ip) check("R8 interrupt word", fetchInstr, INT_W);
    else if (h) check("R2 hit data", fetchInstr, memFn(a));
    else check("R7 NOP on miss", fetchInstr, NOP_W);
    check("R4 request", {31'b0, memReq}, {31'b0, mFill});
    if (mFill) check("R5 fill address", memAddr, ma);
    if (expHit >= 0) check(tag, {31'b0, fetchHit}, 32'(expHit));
    @(posedge clk);
    if (fl) begin
      for (int s = 0; s < 64; s++) mVld[s] = '0;
      mPtr = 0; mFill = 0;
    end else if (mFill) begin
      if (mv) begin
        mVld[mSlot][(mCrit + mBeat) % 4] = 1'b1;
        mBeat++;
        if (mBeat == 4) begin mFill = 0; mPtr = (mPtr + 1) % 64; end
      end
    end else if (!h) begin
      mTag[mPtr] = a[31:4]; mVld[mPtr] = '0; mSlot = mPtr;
      mFill = 1; mFTag = a[31:4]; mCrit = int'(a[3:2]); mBeat = 0;
    end
    #1;
  endtask

  // wait for a word and its whole line to be resident
  task automatic settle(logic [31:0] a);
    for (int g = 0; g < 200 && (mFill || !mHit(a)); g++) step(a, 0, 0, rnd());
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stim
    logic [31:0] pc;
    for (int s = 0; s < 64; s++) begin mVld[s] = '0; mTag[s] = '0; end
    mPtr = 0; mFill = 0; mFTag = '0; mCrit = 0; mBeat = 0; mSlot = 0;
    rstN = 1'b0; flushAll = 1'b0; fetchAddr = 32'h0000_1008;
    intPending = 1'b0; memValid = 1'b0; memData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset hit", {31'b0, fetchHit}, 32'd0);
    check("R10 reset request", {31'b0, memReq}, 32'd0);
    @(posedge clk); #1 rstN = 1'b1;

    // R5/R6: critical word first, early hit, unwritten word still misses
    step(32'h0000_1008, 0, 0, 0, 0, "R7 first miss");
    step(32'h0000_1008, 0, 0, 0);
    step(32'h0000_1008, 0, 0, 1);  // word 2 returned
    step(32'h0000_1008, 0, 0, 0, 1, "R6 critical word hits early");
    step(32'h0000_1004, 0, 0, 0, 0, "R6 unwritten word misses");
    step(32'h0000_2000, 0, 0, 1, 0, "R6 no second fill");
    settle(32'h0000_1004);

    // sequential run with stalls and interrupt pulses (R2, R7, R8)
    pc = 32'h0000_1000;
    for (int c = 0; c < 120; c++) begin
      bit h = mHit(pc);
      step(pc, (c % 17) == 5, 0, rnd());
      if (h) pc = pc + 4;
    end

    // R8: interrupt over a hit leaves hit flag and data path alone
    settle(32'h0000_1000);
    step(32'h0000_1000, 1, 0, 0, 1, "R8 hit flag kept");

    // R3: 65 distinct lines after a flush, first evicted, second kept
    step(32'h0000_1000, 0, 1, 0);
    step(32'h0000_1000, 0, 0, 0, 0, "R9 flush clears");
    settle(32'h0000_1000);
    step(32'h0000_1000, 0, 1, 0);
    for (int k = 0; k < 65; k++) settle(32'h2000_0000 + 32'(k * 16) + 32'((k % 4) * 4));
    step(32'h2000_0014, 0, 0, 0, 1, "R3 second line kept");
    step(32'h2000_0000, 0, 0, 0, 0, "R3 oldest line evicted");
    settle(32'h2000_0000);
    step(32'h2000_0404, 0, 0, 0, 1, "R3 newest line resident");

    // R9: flush during a fill drops it
    step(32'h4000_000C, 0, 0, 0);
    step(32'h4000_000C, 0, 0, 1);
    step(32'h4000_000C, 0, 1, 1);
    step(32'h4000_000C, 0, 0, 0, 0, "R9 fill dropped");
    settle(32'h4000_000C);

    // R4: long memory stall then random wrap orders
    for (int k = 0; k < 8; k++) begin
      logic [31:0] a = 32'h5000_0000 + 32'(k * 16) + 32'((k % 4) * 4);
      step(a, 0, 0, 0);
      for (int w = 0; w < 5; w++) step(a, 0, 0, 0);
      settle(a);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule